// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block merges thirty-two primary interrupt sources and thirty-two secondary sources into one interrupt request for the CPU. The secondary sources fall into three fixed groups. Each group reports upward through one summary line of the primary level, so the secondary level sits beneath three primary bit positions. Every bit on each level is fixed at design time as either level-sensitive or edge-captured. Edge-captured bits hold their event in a latch until software clears it.

Software works through a small register port. It reads and writes the two mask words and the two latch words, and it reads the two status words. Along with the combined request, the block presents a registered vector number with a valid flag. The vector names the one source to service. A pending secondary source outranks every other source. Otherwise the lowest pending primary bit is chosen.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, both masks and both latch words read as zero, and `cpuIrq` and `vecValid` are low.
- R2: A level-sensitive bit of a status word follows its source input. The input passes through a two-flop synchroniser.
- R3: An edge-captured bit sets on a 0-to-1 change of its synchronised input and stays set after the input falls. A latch write replaces the whole latch word, so writing 0 clears a bit and writing 1 sets it. Primary edge bits are 16-19, 22-24 and 28-31.
- R4: Latch positions of level-sensitive bits ignore writes and always read 0.
- R5: When a new edge and a latch write land in the same cycle on the same bit, the bit ends up set.
- R6: Primary status bit 6 is the OR of (secondary status AND secondary mask) over secondary bits 0-7. Bit 5 covers secondary bits 8-15 and bit 4 covers secondary bits 16-31. The primary inputs at bits 4-6 are ignored.
- R7: The primary pending word is primary status AND primary mask. `cpuIrq` is the OR of the pending word, registered once, so it rises on the third clock edge after the source input changes.
- R8: If any of pending primary bits 4-6 is set, `vecNum` is SEC_BASE (default 40) plus the index of the lowest set bit of (secondary status AND secondary mask) over all 32 bits.
- R9: If none of pending bits 4-6 is set, `vecNum` is PRI_BASE (default 8) plus the index of the lowest pending primary bit. With nothing pending, `vecValid` is low.
- R10: A read issued at `regAddr` returns `regRdData` with `regRdValid` one cycle later. The value reflects every write accepted in an earlier cycle. The address map is: 0 primary mask, 1 primary latch, 2 primary status, 3 secondary mask, 4 secondary latch, 5 secondary status. Every other address reads 0.
- R11: Secondary bits 16, 22 and 28 are edge-captured. All other secondary bits are level-sensitive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priSrc | input | 32 | Primary source inputs (bits 4-6 unused) |
| secSrc | input | 32 | Secondary source inputs |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid with regRdValid |
| regRdValid | output | 1 | Read response strobe, one cycle after regRdEn |
| cpuIrq | output | 1 | Combined interrupt request to the CPU |
| vecValid | output | 1 | A vector is available |
| vecNum | output | 7 | Number of the source to service |

## Verification
The bench targets several corner cases, and each one would fail in a visible way if built wrong.
- Cascade precedence: a primary bit below the summary lines is pending alongside a secondary source. A design that simply took the lowest primary bit would report the primary vector.
- Lowest secondary bit across groups: the only unmasked summary line belongs to one group, but the lowest pending secondary bit sits in another group. A design that searched only inside the summarised group would pick the wrong bit.
- Edge set colliding with a latch clear: the edge and a clear land in the same cycle. A clear-wins latch would lose the event.
- Ignored bits: latch writes to level positions and drive on the primary summary inputs must have no effect. A design that stored or passed them would read back ones or raise the request.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int PRI_W  = 32;
  localparam int SEC_W  = 32;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int NGRP   = 3;
  localparam int CASCADE_LO = 4;

  localparam logic [ADDR_W-1:0] A_PRI_MASK  = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRI_LATCH = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRI_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SEC_MASK  = 3'd3;
  localparam logic [ADDR_W-1:0] A_SEC_LATCH = 3'd4;
  localparam logic [ADDR_W-1:0] A_SEC_STAT  = 3'd5;

  typedef struct packed {
    logic              wrPriMask;
    logic              wrPriLatch;
    logic              wrSecMask;
    logic              wrSecLatch;
    logic              rdEn;
    logic [ADDR_W-1:0] rdSel;
  } ctrl_strb_t;

  // Group g drives primary bit CASCADE_LO+g; the secondary span per group:
  // g0 -> 16..31, g1 -> 8..15, g2 -> 0..7
  function automatic int grpLo(int g);
    return (g == 0) ? 16 : (g == 1) ? 8 : 0;
  endfunction

  function automatic int grpHi(int g);
    return (g == 0) ? 31 : (g == 1) ? 15 : 7;
  endfunction

  function automatic logic [SEC_W-1:0] grpMask(int g);
    logic [SEC_W-1:0] m;
    m = '0;
    for (int i = 0; i < SEC_W; i++) begin
      if (i >= grpLo(g) && i <= grpHi(g)) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [PRI_W-1:0] cascadeMask();
    logic [PRI_W-1:0] m;
    m = '0;
    for (int g = 0; g < NGRP; g++) m[CASCADE_LO+g] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cic_capture.sv
module cic_capture #(
  parameter int          W         = 32,
  parameter logic [W-1:0] EDGE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] srcIn,
  input  logic         latchWr,
  input  logic [W-1:0] latchWrData,
  output logic [W-1:0] levelBits,
  output logic [W-1:0] latchBits
);
  logic [W-1:0] meta;
  logic [W-1:0] syncd;
  logic [W-1:0] syncdPrev;
  logic [W-1:0] rise;
  logic [W-1:0] latchNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta      <= '0;
      syncd     <= '0;
      syncdPrev <= '0;
    end else begin
      meta      <= srcIn;
      syncd     <= meta;
      syncdPrev <= syncd;
    end
  end

  assign rise = syncd & ~syncdPrev & EDGE_MASK;

  // software word replaces the latch, a fresh edge is OR-ed on top
  always_comb begin
    latchNext = ((latchWr ? latchWrData : latchBits) | rise) & EDGE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latchBits <= '0;
    else        latchBits <= latchNext;
  end

  assign levelBits = syncd & ~EDGE_MASK;

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !latchWr |=> ((latchBits & $past(latchBits)) == $past(latchBits))); // R3
  AST_WR_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
    (latchWr && rise == '0) |=> (latchBits == ($past(latchWrData) & EDGE_MASK))); // R3
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((latchBits & $past(rise)) == $past(rise))); // R5
endmodule

// File: rtl/cic_lowbit.sv
module cic_lowbit #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  bits,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |bits;
    for (int i = W - 1; i >= 0; i--) begin
      if (bits[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrl_strb_t        strb
);
  always_comb begin
    strb = '0;
    if (regWrEn) begin
      case (regAddr)
        A_PRI_MASK:  strb.wrPriMask  = 1'b1;
        A_PRI_LATCH: strb.wrPriLatch = 1'b1;
        A_SEC_MASK:  strb.wrSecMask  = 1'b1;
        A_SEC_LATCH: strb.wrSecLatch = 1'b1;
        default: ;
      endcase
    end
    strb.rdEn  = regRdEn;
    strb.rdSel = regAddr;
  end

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.wrPriMask, strb.wrPriLatch, strb.wrSecMask, strb.wrSecLatch})); // R10
endmodule

// File: rtl/cic_datapath.sv
module cic_datapath
  import cic_pkg::*;
#(
  parameter logic [PRI_W-1:0] PRI_EDGE = 32'hF1CF_0000,
  parameter logic [SEC_W-1:0] SEC_EDGE = 32'h1041_0000,
  parameter int               PRI_BASE = 8,
  parameter int               SEC_BASE = 40,
  parameter int               VEC_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRI_W-1:0]  priSrc,
  input  logic [SEC_W-1:0]  secSrc,
  input  ctrl_strb_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              cpuIrq,
  output logic              vecValid,
  output logic [VEC_W-1:0]  vecNum
);
  localparam logic [PRI_W-1:0] CASC_MASK  = cascadeMask();
  localparam logic [PRI_W-1:0] PRI_EDGE_E = PRI_EDGE & ~CASC_MASK;
  localparam int PIW = $clog2(PRI_W);
  localparam int SIW = $clog2(SEC_W);

  logic [PRI_W-1:0] priMask, priLevel, priLatch, priStat, priPend, cascadeBits;
  logic [SEC_W-1:0] secMask, secLevel, secLatch, secStat, secPend;
  logic [NGRP-1:0]  grpHit;
  logic [PIW-1:0]   priIdx;
  logic [SIW-1:0]   secIdx;
  logic             priAny, secAny, cascadeHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priMask <= '0;
      secMask <= '0;
    end else begin
      if (strb.wrPriMask) priMask <= wrData;
      if (strb.wrSecMask) secMask <= wrData;
    end
  end

  cic_capture #(.W(PRI_W), .EDGE_MASK(PRI_EDGE_E)) u_priCap (
    .clk(clk), .rst_n(rst_n), .srcIn(priSrc),
    .latchWr(strb.wrPriLatch), .latchWrData(wrData),
    .levelBits(priLevel), .latchBits(priLatch));

  cic_capture #(.W(SEC_W), .EDGE_MASK(SEC_EDGE)) u_secCap (
    .clk(clk), .rst_n(rst_n), .srcIn(secSrc),
    .latchWr(strb.wrSecLatch), .latchWrData(wrData),
    .levelBits(secLevel), .latchBits(secLatch));

  assign secStat = secLevel | secLatch;
  assign secPend = secStat & secMask;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [SEC_W-1:0] GMASK = grpMask(g);
    assign grpHit[g] = |(secPend & GMASK);
  end

  always_comb begin
    cascadeBits = '0;
    for (int g = 0; g < NGRP; g++) cascadeBits[CASCADE_LO+g] = grpHit[g];
  end

  assign priStat    = (priLevel & ~CASC_MASK) | priLatch | cascadeBits;
  assign priPend    = priStat & priMask;
  assign cascadeHit = |(priPend & CASC_MASK);

  cic_lowbit #(.W(PRI_W)) u_priLow (.bits(priPend), .idx(priIdx), .any(priAny));
  cic_lowbit #(.W(SEC_W)) u_secLow (.bits(secPend), .idx(secIdx), .any(secAny));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpuIrq   <= 1'b0;
      vecValid <= 1'b0;
      vecNum   <= '0;
    end else begin
      cpuIrq   <= priAny;
      vecValid <= priAny;
      if (cascadeHit && secAny) vecNum <= VEC_W'(SEC_BASE) + VEC_W'(secIdx);
      else if (priAny)          vecNum <= VEC_W'(PRI_BASE) + VEC_W'(priIdx);
      else                      vecNum <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.rdEn;
      if (strb.rdEn) begin
        case (strb.rdSel)
          A_PRI_MASK:  rdData <= priMask;
          A_PRI_LATCH: rdData <= priLatch;
          A_PRI_STAT:  rdData <= priStat;
          A_SEC_MASK:  rdData <= secMask;
          A_SEC_LATCH: rdData <= secLatch;
          A_SEC_STAT:  rdData <= secStat;
          default:     rdData <= '0;
        endcase
      end
    end
  end

  AST_CASCADE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cascadeHit |=> (vecValid && vecNum >= VEC_W'(SEC_BASE) && vecNum < VEC_W'(SEC_BASE + SEC_W))); // R8
  AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (priPend == '0) |=> (!vecValid && !cpuIrq)); // R9
  AST_PRI_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (priAny && !cascadeHit) |=> (vecNum >= VEC_W'(PRI_BASE) && vecNum < VEC_W'(PRI_BASE + PRI_W))); // R9
  AST_RD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdEn |=> rdValid); // R10
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrPriMask |=> $stable(priMask)); // R10
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cic_pkg::*;
#(
  parameter logic [31:0] PRI_EDGE = 32'hF1CF_0000,
  parameter logic [31:0] SEC_EDGE = 32'h1041_0000,
  parameter int          PRI_BASE = 8,
  parameter int          SEC_BASE = 40,
  parameter int          VEC_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       priSrc,
  input  logic [31:0]       secSrc,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              regRdValid,
  output logic              cpuIrq,
  output logic              vecValid,
  output logic [VEC_W-1:0]  vecNum
);
  ctrl_strb_t strb;

  cic_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .strb(strb));

  cic_datapath #(
    .PRI_EDGE(PRI_EDGE), .SEC_EDGE(SEC_EDGE),
    .PRI_BASE(PRI_BASE), .SEC_BASE(SEC_BASE), .VEC_W(VEC_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .priSrc(priSrc), .secSrc(secSrc),
    .strb(strb), .wrData(regWrData), .rdData(regRdData), .rdValid(regRdValid),
    .cpuIrq(cpuIrq), .vecValid(vecValid), .vecNum(vecNum));
endmodule

// File: tb/cascade_irq_ctrl_tb.sv
module cascade_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] pri;
    logic [31:0] sec;
    logic [31:0] pm;
    logic [31:0] sm;
    logic        irq;
    logic [6:0]  vec;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0001, 32'h0,          32'hFFFF_FFFF, 32'h0,          1'b1, 7'd8 },  // R9
    '{32'h0000_0088, 32'h0,          32'hFFFF_FFFF, 32'h0,          1'b1, 7'd11},  // R9
    '{32'h0000_0100, 32'h0,          32'hFFFF_FEFF, 32'h0,          1'b0, 7'd0 },  // R7
    '{32'h0000_0001, 32'h0000_1200,  32'hFFFF_FFFF, 32'hFFFF_FFFF,  1'b1, 7'd49},  // R8
    '{32'h0000_0004, 32'h0000_0200,  32'hFFFF_FFFF, 32'h0,          1'b1, 7'd10},  // R6
    '{32'h0000_0020, 32'h0,          32'hFFFF_FFFF, 32'hFFFF_FFFF,  1'b0, 7'd0 },  // R6
    '{32'h0,         32'h0010_0000,  32'h0000_0010, 32'h0010_0000,  1'b1, 7'd60},  // R6
    '{32'h0010_0000, 32'h0000_0008,  32'hFFFF_FFBF, 32'hFFFF_FFFF,  1'b1, 7'd28},  // R6
    '{32'h0800_0000, 32'h0,          32'hFFFF_FFFF, 32'h0,          1'b1, 7'd35},  // R9
    '{32'h0,         32'h0400_0002,  32'h0000_0010, 32'hFFFF_FFFF,  1'b1, 7'd41},  // R8
    '{32'h0020_2000, 32'h0,          32'hFFFF_FFFF, 32'h0,          1'b1, 7'd21}   // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] priSrc = '0;
  logic [31:0] secSrc = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        regRdValid;
  logic        cpuIrq;
  logic        vecValid;
  logic [6:0]  vecNum;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .priSrc(priSrc), .secSrc(secSrc),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .regRdValid(regRdValid),
    .cpuIrq(cpuIrq), .vecValid(vecValid), .vecNum(vecNum));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData; v = regRdValid;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cpuIrq", {31'b0, cpuIrq}, 32'h0);
    check("R1 vecValid", {31'b0, vecValid}, 32'h0);
    rd(3'd0, d, v); check("R1 priMask", d, 32'h0);
    rd(3'd1, d, v); check("R1 priLatch", d, 32'h0);
    rd(3'd3, d, v); check("R1 secMask", d, 32'h0);
    rd(3'd4, d, v); check("R1 secLatch", d, 32'h0);

    // table walk, level sources only
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, VECS[i].pm);
      wr(3'd3, VECS[i].sm);
      priSrc = VECS[i].pri;
      secSrc = VECS[i].sec;
      settle();
      check($sformatf("R7 irq vec%0d", i), {31'b0, cpuIrq}, {31'b0, VECS[i].irq});
      check($sformatf("R9 valid vec%0d", i), {31'b0, vecValid}, {31'b0, VECS[i].irq});
      if (VECS[i].irq)
        check($sformatf("R8 num vec%0d", i), {25'b0, vecNum}, {25'b0, VECS[i].vec});
    end
    priSrc = '0; secSrc = '0;
    settle();

    // R10 read right after write, address map
    wr(3'd0, 32'h1234_5678);
    rd(3'd0, d, v);
    check("R10 readback", d, 32'h1234_5678);
    check("R10 rdValid", {31'b0, v}, 32'h1);
    wr(3'd3, 32'hA5A5_0F0F);
    rd(3'd3, d, v); check("R10 sec readback", d, 32'hA5A5_0F0F);
    rd(3'd6, d, v); check("R10 unmapped", d, 32'h0);

    // R2 and R6: status reflects levels, primary summary inputs ignored
    wr(3'd3, 32'h0);
    priSrc = 32'h0000_0270;
    settle();
    rd(3'd2, d, v); check("R2 R6 priStatus", d, 32'h0000_0200);
    priSrc = '0;
    settle();
    rd(3'd2, d, v); check("R2 priStatus low", d, 32'h0);

    // R7 request latency: third edge after input change
    wr(3'd0, 32'h0000_0001);
    @(negedge clk);
    priSrc[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7 irq before 3rd edge", {31'b0, cpuIrq}, 32'h0);
    @(negedge clk);
    check("R7 irq at 3rd edge", {31'b0, cpuIrq}, 32'h1);
    priSrc = '0;
    settle();

    // R3 edge capture and sticky latch
    wr(3'd0, 32'h0001_0000);
    @(negedge clk); priSrc[16] = 1'b1;
    repeat (3) @(negedge clk); priSrc[16] = 1'b0;
    settle();
    rd(3'd1, d, v); check("R3 latch set", d, 32'h0001_0000);
    check("R3 irq held", {31'b0, cpuIrq}, 32'h1);
    check("R3 vec 24", {25'b0, vecNum}, 32'd24);
    wr(3'd1, 32'h0);
    settle();
    rd(3'd1, d, v); check("R3 latch cleared", d, 32'h0);
    check("R3 irq dropped", {31'b0, cpuIrq}, 32'h0);

    // R3 and R4: writing ones sets only edge positions
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d, v); check("R4 level positions read 0", d, 32'hF1CF_0000);
    wr(3'd1, 32'h0);
    rd(3'd1, d, v); check("R3 cleared by write", d, 32'h0);

    // R5 edge and clear in the same cycle
    wr(3'd0, 32'h0);
    @(negedge clk); priSrc[17] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd1; regWrData = 32'h0;
    @(negedge clk);
    regWrEn = 1'b0;
    priSrc[17] = 1'b0;
    rd(3'd1, d, v); check("R5 edge survives clear", d, 32'h0002_0000);
    wr(3'd1, 32'h0);

    // R11 secondary edge bit 22 through summary bit 4
    wr(3'd0, 32'h0000_0010);
    wr(3'd3, 32'h0060_0000);
    @(negedge clk); secSrc[22] = 1'b1;
    repeat (3) @(negedge clk); secSrc[22] = 1'b0;
    settle();
    rd(3'd4, d, v); check("R11 secLatch bit22", d, 32'h0040_0000);
    check("R11 vec 62", {25'b0, vecNum}, 32'd62);
    wr(3'd4, 32'h0);
    @(negedge clk); secSrc[21] = 1'b1;
    repeat (3) @(negedge clk); secSrc[21] = 1'b0;
    settle();
    check("R11 level bit21 not held", {31'b0, vecValid}, 32'h0);
    rd(3'd4, d, v); check("R11 secLatch empty", d, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule